// File: doc/BRIEF.md
# Parallel EEPROM page-write controller

This block is a clocked model of the write-control path of a byte-wide parallel EEPROM. It samples active-low chip-enable, output-enable and write-enable strobes together with an address and a data bus. It decodes the bus mode from those strobes and collects loaded bytes in a 32-byte page buffer. After a quiet load window it copies the buffered bytes into its storage array with a self-timed commit. During that commit a read returns a polling bit and a toggling bit in place of the stored data, so that host software can detect when the write has finished.

All durations are parameters counted in clock cycles: the minimum write-strobe width, the load window, the commit time and the write lockout after reset. The address width is a parameter. The default of 10 bits keeps the model small. Setting it to 13 gives the full 8192-byte organisation. The upper address bits always select the page, and the lowest five bits always select the byte within it.

Top module: `eeprom_page_wr`

## Requirements
- R1: The address splits into a page number (bits ADDR_W-1 down to 5) and a byte offset (bits 4 down to 0) within a 32-byte page. When no commit is running, a read returns the byte stored at the addressed location.
- R2: `data_oe` is 1 only for ce_n=0, oe_n=0, we_n=1 (read). It is 0 in standby (ce_n=1), in the active idle state (ce_n=0, oe_n=1, we_n=1), and whenever we_n=0.
- R3: A byte is loaded by a write strobe, meaning the cycles with ce_n=0, oe_n=1 and we_n=0. The strobe may be ended either by we_n or by ce_n rising. The address is taken in the first cycle of the strobe and the data in its last cycle. Bus changes after the strobe ends do not alter the loaded byte.
- R4: Every accepted strobe end starts the load window of BLC_CYC cycles. A new strobe that begins before the window runs out cancels it, and its byte joins the same page. A page holds from 1 to 32 bytes.
- R5: When the window expires, the commit runs for WC_CYC cycles (at least 32). Strobes during the commit load nothing. The page buffer is emptied at the end, so the next page writes only its own bytes.
- R6: A strobe lasting fewer than GLITCH_CYC clock cycles loads nothing. A strobe of exactly GLITCH_CYC cycles is loaded.
- R7: For INHIBIT_CYC cycles after reset is released, strobes load nothing.
- R8: During the commit, a read returns on data bit 7 the inverse of bit 7 of the last loaded byte. After the commit, it returns the stored byte.
- R9: During the commit, data bit 6 changes value between successive reads. After the commit, bit 6 is the stored data bit and repeats from read to read.
- R10: A load to a different page inside one window moves the page number to the new page. All loaded bytes are written at their offsets in the latest page. The earlier page and the unloaded offsets keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data bus |
| data_out | output | 8 | Read data, or status during a commit |
| data_oe | output | 1 | Drive enable for the data bus |

## Verification
The page function is driven with several patterns, and each one separates different faults:
- Multi-byte pages with short gaps between strobes show whether the window keeps running bytes in one page.
- Pages ended by ce_n instead of we_n check that either strobe can end a write.
- A full 32-byte page exercises every offset.
- Two loads to different pages within one window show whether the page number is replaced and whether untouched bytes survive.

Strobes one cycle shorter than the minimum and exactly at the minimum bound the glitch filter. Strobes sent during a commit and right after reset show that loads are locked out. Repeated reads during and after a commit tell the polling bit and the toggle bit apart from stored data.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BUS_OFF  = 2'd0,
    BUS_IDLE = 2'd1,
    BUS_READ = 2'd2,
    BUS_LOAD = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/eeprom_pw_mode_dec.sv
module eeprom_pw_mode_dec
  import eeprom_pw_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  output bus_mode_e mode
);
  always_comb begin
    if (ce_n)               mode = BUS_OFF;
    else if (!we_n && oe_n) mode = BUS_LOAD;
    else if (we_n && !oe_n) mode = BUS_READ;
    else                    mode = BUS_IDLE;
  end
endmodule

// File: rtl/eeprom_pw_loader.sv
module eeprom_pw_loader
  import eeprom_pw_pkg::*;
#(
  parameter  int ADDR_W     = 13,
  parameter  int OFF_W      = 5,
  parameter  int GLITCH_CYC = 2,
  parameter  int BLC_CYC    = 8,
  localparam int PAGE       = 1 << OFF_W,
  localparam int PG_W       = ADDR_W - OFF_W
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            din,
  input  logic                         load_ok,
  input  logic                         commit_done,
  output logic                         commit_req,
  output logic [PG_W-1:0]              page_addr,
  output logic [PAGE-1:0][BYTE_W-1:0]  page_data,
  output logic [PAGE-1:0]              page_vld,
  output logic                         last_bit7
);
  localparam int LEN_W = $clog2(GLITCH_CYC + 1);
  localparam int BLC_W = $clog2(BLC_CYC + 1);

  logic              wr_q;
  logic [LEN_W-1:0]  wlen_q, wlen_d;
  logic [BLC_W-1:0]  blc_q, blc_d;
  logic [PAGE-1:0]   vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE-1:0][BYTE_W-1:0] buf_q;
  logic              b7_q;

  logic              strobe_end, long_enough, accept, any_vld;
  logic [OFF_W-1:0]  off;

  always_comb begin
    strobe_end  = wr_q && !strobe;
    long_enough = (wlen_q >= LEN_W'(GLITCH_CYC));
    accept      = strobe_end && long_enough && load_ok;
    any_vld     = (vld_q != '0);
    off         = addr_q[OFF_W-1:0];

    wlen_d = '0;
    if (strobe) wlen_d = long_enough ? wlen_q : wlen_q + LEN_W'(1);

    if (strobe)
      blc_d = '0;
    else if (strobe_end && load_ok && (accept || any_vld))
      blc_d = BLC_W'(BLC_CYC);
    else if (blc_q != '0)
      blc_d = blc_q - BLC_W'(1);
    else
      blc_d = blc_q;

    commit_req = (blc_q == BLC_W'(1)) && !strobe && any_vld && load_ok;

    if (commit_done)  vld_d = '0;
    else if (accept)  vld_d = vld_q | (PAGE'(1) << off);
    else              vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wlen_q <= '0;
      blc_q  <= '0;
      vld_q  <= '0;
    end else begin
      wr_q   <= strobe;
      wlen_q <= wlen_d;
      blc_q  <= blc_d;
      vld_q  <= vld_d;
    end
  end

  // datapath registers: no reset, qualified by enables
  always_ff @(posedge clk) begin
    if (strobe && !wr_q) addr_q <= addr;
    if (strobe)          data_q <= din;
    if (accept) begin
      page_q     <= addr_q[ADDR_W-1:OFF_W];
      buf_q[off] <= data_q;
      b7_q       <= data_q[BYTE_W-1];
    end
  end

  assign page_addr = page_q;
  assign page_data = buf_q;
  assign page_vld  = vld_q;
  assign last_bit7 = b7_q;
endmodule

// File: rtl/eeprom_pw_commit.sv
module eeprom_pw_commit
  import eeprom_pw_pkg::*;
#(
  parameter  int ADDR_W      = 13,
  parameter  int OFF_W       = 5,
  parameter  int WC_CYC      = 40,
  parameter  int INHIBIT_CYC = 20,
  localparam int PAGE        = 1 << OFF_W,
  localparam int PG_W        = ADDR_W - OFF_W
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit_req,
  input  logic [PG_W-1:0]              page_addr,
  input  logic [PAGE-1:0][BYTE_W-1:0]  page_data,
  input  logic [PAGE-1:0]              page_vld,
  input  logic                         last_bit7,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rd_active,
  output logic                         busy,
  output logic                         inhibit,
  output logic                         commit_done,
  output logic [BYTE_W-1:0]            rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WC_EFF = (WC_CYC > PAGE) ? WC_CYC : PAGE;
  localparam int WC_W   = $clog2(WC_EFF);
  localparam int SW_W   = OFF_W + 1;
  localparam int INH_W  = $clog2(INHIBIT_CYC + 1);

  logic              busy_q, busy_d;
  logic [WC_W-1:0]   wc_q, wc_d;
  logic [SW_W-1:0]   sweep_q, sweep_d;
  logic [INH_W-1:0]  inh_q, inh_d;
  logic              tog_q, tog_d;
  logic              rd_q;
  logic              sweeping, mem_we;
  logic [OFF_W-1:0]  slot;
  logic [ADDR_W-1:0] mem_wa;
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] stored;

  always_comb begin
    commit_done = busy_q && (wc_q == '0);
    sweeping    = busy_q && (sweep_q < SW_W'(PAGE));
    slot        = sweep_q[OFF_W-1:0];
    mem_we      = sweeping && page_vld[slot];
    mem_wa      = {page_addr, slot};

    busy_d  = commit_req ? 1'b1 : (commit_done ? 1'b0 : busy_q);
    wc_d    = commit_req ? WC_W'(WC_EFF - 1)
            : ((busy_q && wc_q != '0) ? wc_q - WC_W'(1) : wc_q);
    sweep_d = commit_req ? '0 : (sweeping ? sweep_q + SW_W'(1) : sweep_q);
    inh_d   = (inh_q != '0) ? inh_q - INH_W'(1) : inh_q;
    tog_d   = (busy_q && rd_q && !rd_active) ? ~tog_q : tog_q;

    stored  = mem[rd_addr];
    rd_data = busy_q ? {~last_bit7, tog_q, stored[BYTE_W-3:0]} : stored;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wc_q    <= '0;
      sweep_q <= '0;
      inh_q   <= INH_W'(INHIBIT_CYC);
      tog_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      wc_q    <= wc_d;
      sweep_q <= sweep_d;
      inh_q   <= inh_d;
      tog_q   <= tog_d;
      rd_q    <= rd_active;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= page_data[slot];
  end

  assign busy    = busy_q;
  assign inhibit = (inh_q != '0);
endmodule

// File: rtl/eeprom_page_wr.sv
module eeprom_page_wr
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int GLITCH_CYC  = 2,
  parameter int BLC_CYC     = 8,
  parameter int WC_CYC      = 40,
  parameter int INHIBIT_CYC = 20
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe
);
  localparam int OFF_W = 5;
  localparam int PAGE  = 1 << OFF_W;
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [1:0]  rst_sync;
  logic        rst_int_n;
  bus_mode_e   mode;
  logic        busy, inhibit, commit_req, commit_done, last_bit7;
  logic [PG_W-1:0]             page_addr;
  logic [PAGE-1:0][BYTE_W-1:0] page_data;
  logic [PAGE-1:0]             page_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  eeprom_pw_mode_dec u_dec (
    .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n), .mode (mode)
  );

  eeprom_pw_loader #(
    .ADDR_W (ADDR_W), .OFF_W (OFF_W),
    .GLITCH_CYC (GLITCH_CYC), .BLC_CYC (BLC_CYC)
  ) u_load (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .strobe      (mode == BUS_LOAD),
    .addr        (addr),
    .din         (data_in),
    .load_ok     (!busy && !inhibit),
    .commit_done (commit_done),
    .commit_req  (commit_req),
    .page_addr   (page_addr),
    .page_data   (page_data),
    .page_vld    (page_vld),
    .last_bit7   (last_bit7)
  );

  eeprom_pw_commit #(
    .ADDR_W (ADDR_W), .OFF_W (OFF_W),
    .WC_CYC (WC_CYC), .INHIBIT_CYC (INHIBIT_CYC)
  ) u_cmt (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .commit_req  (commit_req),
    .page_addr   (page_addr),
    .page_data   (page_data),
    .page_vld    (page_vld),
    .last_bit7   (last_bit7),
    .rd_addr     (addr),
    .rd_active   (mode == BUS_READ),
    .busy        (busy),
    .inhibit     (inhibit),
    .commit_done (commit_done),
    .rd_data     (data_out)
  );

  assign data_oe = (mode == BUS_READ);
endmodule

// File: rtl/eeprom_page_wr_chk.sv
module eeprom_page_wr_chk #(
  parameter int PAGE = 32
)(
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            data_oe,
  input logic [7:0]      data_out,
  input logic            busy,
  input logic            inhibit,
  input logic            commit_req,
  input logic            commit_done,
  input logic [PAGE-1:0] page_vld,
  input logic            last_bit7
);
  assert_oe_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ce_n && !oe_n && we_n));

  assert_no_oe_we_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !data_oe);

  assert_commit_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> (page_vld != '0));

  assert_commit_not_nested_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> !busy);

  assert_no_load_in_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_done) |=> $stable(page_vld));

  assert_buffer_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (page_vld == '0));

  assert_no_commit_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !commit_req);

  assert_poll_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_oe) |-> (data_out[7] == !last_bit7));
endmodule

bind eeprom_page_wr eeprom_page_wr_chk #(.PAGE(PAGE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .data_oe     (data_oe),
  .data_out    (data_out),
  .busy        (busy),
  .inhibit     (inhibit),
  .commit_req  (commit_req),
  .commit_done (commit_done),
  .page_vld    (page_vld),
  .last_bit7   (last_bit7)
);

// File: tb/eeprom_page_wr_bench.sv
`timescale 1ns/1ps
module eeprom_page_wr_bench;
  localparam int AW = 10, GL = 2, BLC = 8, WC = 40, INH = 20;
  localparam int WAITC = BLC + WC + 12;
  localparam int NV = 29;
  // {kind, addr, data}: kind 0 = we-ended load, 1 = ce-ended load, 2 = wait for commit, 3 = read check
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 10'h061, 8'h11}, {2'd0, 10'h062, 8'hC3}, {2'd1, 10'h063, 8'h7E}, {2'd2, 10'h000, 8'h00},
    {2'd0, 10'h0A1, 8'hA5}, {2'd1, 10'h0A2, 8'h3C}, {2'd0, 10'h0A3, 8'h96}, {2'd2, 10'h000, 8'h00},
    {2'd0, 10'h0C5, 8'h44}, {2'd2, 10'h000, 8'h00},
    {2'd0, 10'h101, 8'h81}, {2'd2, 10'h000, 8'h00},
    {2'd0, 10'h121, 8'h91}, {2'd0, 10'h122, 8'h92}, {2'd0, 10'h123, 8'h93}, {2'd2, 10'h000, 8'h00},
    {2'd1, 10'h162, 8'h55}, {2'd2, 10'h000, 8'h00},
    {2'd3, 10'h061, 8'h11}, {2'd3, 10'h062, 8'hC3}, {2'd3, 10'h063, 8'h7E},
    {2'd3, 10'h0A1, 8'hA5}, {2'd3, 10'h0A2, 8'h3C}, {2'd3, 10'h0A3, 8'h96},
    {2'd3, 10'h0C5, 8'h44}, {2'd3, 10'h101, 8'h81}, {2'd3, 10'h121, 8'h91},
    {2'd3, 10'h122, 8'h92}, {2'd3, 10'h162, 8'h55}
  };

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0] data_in, data_out;
  logic data_oe;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eeprom_page_wr #(.ADDR_W(AW), .GLITCH_CYC(GL), .BLC_CYC(BLC),
                   .WC_CYC(WC), .INHIBIT_CYC(INH)) u_eeprom_page_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_we(input logic [AW-1:0] a, input logic [7:0] d, input int low);
    @(negedge clk);
    addr = a; data_in = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (low) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; addr = ~a; data_in = ~d;
    @(negedge clk);
  endtask

  task automatic load_ce(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data_in = d; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk) ce_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; addr = ~a; data_in = ~d;
    @(negedge clk) we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #5; v = data_out; oe = data_oe;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] v; logic oe;
    rd(a, v, oe);
    chk(tag, v, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v1, v2, v3; logic oe;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; data_in = '0;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R2 standby oe after reset", {7'd0, data_oe}, 8'h00);
    idle_cycles(INH + 6);

    // R2: active idle and load modes keep the bus undriven
    @(negedge clk); ce_n = 1'b0; #5;
    chk("R2 active idle oe", {7'd0, data_oe}, 8'h00);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; #5;
    chk("R2 oe with we low", {7'd0, data_oe}, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    idle_cycles(WAITC);

    // vector table: R1 R3 R4 pages via we and ce strobes
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:18])
        2'd0: load_we(VEC[i][17:8], VEC[i][7:0], 3);
        2'd1: load_ce(VEC[i][17:8], VEC[i][7:0]);
        2'd2: idle_cycles(WAITC);
        default: rd_chk("R1 R3 R4 table read", VEC[i][17:8], VEC[i][7:0]);
      endcase
    end
    rd(10'h061, v1, oe);
    chk("R2 read oe", {7'd0, oe}, 8'h01);

    // R4: full 32-byte page
    for (int i = 0; i < 32; i++) load_we(10'h140 + AW'(i), 8'(i * 7 + 1), 3);
    idle_cycles(WAITC);
    for (int i = 0; i < 32; i++) rd_chk("R4 full page", 10'h140 + AW'(i), 8'(i * 7 + 1));

    // R8 R9 R5: status during commit and ignored load
    load_we(10'h0C4, 8'h5A, 3);
    idle_cycles(BLC + 2);
    rd(10'h0C4, v1, oe);
    chk("R8 poll bit7 during commit", {7'd0, v1[7]}, 8'h01);
    rd(10'h0C4, v2, oe);
    chk("R9 toggle second read", {7'd0, v2[6]}, {7'd0, ~v1[6]});
    rd(10'h0C4, v3, oe);
    chk("R9 toggle third read", {7'd0, v3[6]}, {7'd0, v1[6]});
    load_we(10'h0C5, 8'hFF, 3);
    idle_cycles(WAITC);
    rd_chk("R8 true data after commit", 10'h0C4, 8'h5A);
    rd_chk("R5 load during commit ignored", 10'h0C5, 8'h44);
    rd(10'h0C4, v1, oe);
    rd(10'h0C4, v2, oe);
    chk("R9 no toggle after commit", {7'd0, v2[6]}, 8'h01);
    chk("R9 stable after commit", v2, v1);

    // R6: glitch rejected, minimum width accepted
    load_we(10'h0C4, 8'h01, GL - 1);
    idle_cycles(WAITC);
    rd_chk("R6 short strobe ignored", 10'h0C4, 8'h5A);
    load_we(10'h0C6, 8'h2B, GL);
    idle_cycles(WAITC);
    rd_chk("R6 minimum strobe accepted", 10'h0C6, 8'h2B);

    // R10: page number replaced within one window
    load_we(10'h101, 8'hE1, 3);
    load_we(10'h122, 8'hE2, 3);
    idle_cycles(WAITC);
    rd_chk("R10 moved byte", 10'h121, 8'hE1);
    rd_chk("R10 new byte", 10'h122, 8'hE2);
    rd_chk("R10 old page kept", 10'h101, 8'h81);
    rd_chk("R10 unloaded offset kept", 10'h123, 8'h93);

    // R5: buffer emptied, next page writes only its own bytes
    load_we(10'h161, 8'h77, 3);
    idle_cycles(WAITC);
    rd_chk("R5 next page byte", 10'h161, 8'h77);
    rd_chk("R5 stale byte not rewritten", 10'h162, 8'h55);

    // R7: lockout after reset
    @(negedge clk); rst_n = 1'b0;
    idle_cycles(3);
    rst_n = 1'b1;
    load_we(10'h0C4, 8'h99, 3);
    idle_cycles(WAITC);
    rd_chk("R7 load after reset ignored", 10'h0C4, 8'h5A);
    load_we(10'h0C4, 8'h99, 3);
    idle_cycles(WAITC);
    rd_chk("R7 load after lockout", 10'h0C4, 8'h99);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule